// File: doc/BRIEF.md
# Multi-Word Mailbox Message Framer

This engine moves variable-length messages between a local word buffer and a mailbox made of four word registers. Each mailbox register is modelled as its own ready/valid word channel. On the transmit side the ready bit of a lane means "register empty". On the receive side the valid bit means "register full". The engine reads the message header from buffer address 0 and checks the length it carries. It then streams the words out one at a time, each word waiting for the flag of its own register. Reception works the same way in the other direction, and each arriving word is written into the buffer at its word index.

A request names one of three operations: send, receive, or call. A call sends the request message and then, unless the no-response flag was given with the request, receives the reply into the same buffer. The header word always travels through register 0 and states the total word count, header included. Later words rotate through the registers by index. The block reports completion with a one-cycle done pulse, and raises an error flag on that same pulse when a length check failed.

Top module: `mbox_msg_framer`

## Requirements
- R1: The header (word 0) of every sent or received message uses mailbox register 0. Its bits 15:8 give the message length in words, and that count includes the header.
- R2: Word k of a message uses buffer address k and mailbox register k mod 4. At most one transmit valid or one receive ready is high in any cycle.
- R3: A word moves only in a cycle where its register's flag (tx_ready for send, rx_valid for receive) is high. Until then the engine holds its request on the same lane, and no buffer write happens without a receive handshake.
- R4: A send whose header length exceeds MAX_WORDS (default 8) sends no word and finishes with done and err high together.
- R5: A received header whose length exceeds MAX_WORDS is stored as zero at buffer address 0. No further word is taken, and the operation finishes with done and err high.
- R6: A header length of 0 or 1 transfers the header word only.
- R7: Operation encoding on req_op: 2'b00 send, 2'b01 receive, 2'b10 or 2'b11 call. A call sends the full request, then receives the reply into the same buffer unless req_no_resp was high at acceptance. A call whose send fails the length check receives nothing.
- R8: A request is accepted only while busy is low. busy is high from the cycle after acceptance until the cycle in which done pulses. done lasts exactly one cycle. A request made while busy has no effect.
- R9: After reset busy, done and err are low, and no transmit valid and no receive ready is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start an operation (taken when idle) |
| req_op | input | 2 | Operation: 00 send, 01 receive, 1x call |
| req_no_resp | input | 1 | Call without waiting for a reply |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Length check failed, valid with done |
| buf_addr | output | 3 | Buffer word address (word index) |
| buf_rd_data | input | 32 | Buffer read data at buf_addr (same cycle) |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_data | output | 32 | Buffer write data |
| tx_valid | output | 4 | Per-register transmit valid |
| tx_data | output | 32 | Transmit word, shared by all registers |
| tx_ready | input | 4 | Per-register transmit-empty flag |
| rx_valid | input | 4 | Per-register receive-full flag |
| rx_data | input | 128 | Receive words, register n at bits 32n+31:32n |
| rx_ready | output | 4 | Per-register receive acknowledge |

## Verification
The assertions check on every cycle the properties of a single cycle or a pair of cycles. These are: the header lane is register 0, lane selection follows the word index, and at most one lane is active. They also check that a pending request holds until its flag arrives, that no transmit starts on an oversized header, that an oversized received header is written as zero, and that done and busy follow their pulse and hand-over rules. Other behaviour shows only across whole operations, so only the bench scenarios can show it. This covers the exact number of words moved for each length from 0 to 10, the data that lands in each buffer address, and the fact that words beyond the stated length stay in the mailbox. It also covers a call chaining into a reply or stopping because of the no-response flag, under both free-running and randomly stalled mailbox flags.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_RECV = 2'd2
   } mbf_state_e;

   localparam logic [1:0] OP_SEND = 2'b00;
   localparam logic [1:0] OP_RECV = 2'b01;
endpackage

// File: rtl/mbf_len_check.sv
module mbf_len_check #(
   parameter int LEN_W     = 8,
   parameter int MAX_WORDS = 8,
   parameter int CNT_W     = 4
) (
   input  logic [LEN_W-1:0] len_field,
   output logic             oversize,
   output logic [CNT_W-1:0] eff_len
);
   // Lengths 0 and 1 both mean a lone header word.
   always_comb begin
      oversize = (int'(len_field) > MAX_WORDS);
      eff_len  = (int'(len_field) <= 1) ? CNT_W'(1) : CNT_W'(len_field);
   end
endmodule

// File: rtl/mbf_lane_sel.sv
module mbf_lane_sel #(
   parameter int NUM_REGS = 4,
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 3
) (
   input  logic                       tx_act,
   input  logic                       rx_act,
   input  logic [IDX_W-1:0]           idx,
   input  logic [NUM_REGS-1:0]        tx_ready,
   input  logic [NUM_REGS-1:0]        rx_valid,
   input  logic [NUM_REGS*DATA_W-1:0] rx_data,
   output logic [NUM_REGS-1:0]        tx_valid,
   output logic [NUM_REGS-1:0]        rx_ready,
   output logic [DATA_W-1:0]          rx_word,
   output logic                       xfer
);
   localparam int LANE_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   logic [LANE_W-1:0] lane;

   // Word index modulo register count picks the lane.
   assign lane = LANE_W'(int'(idx) % NUM_REGS);

   genvar g;
   generate
      for (g = 0; g < NUM_REGS; g++) begin : g_lane
         assign tx_valid[g] = tx_act && (lane == LANE_W'(g));
         assign rx_ready[g] = rx_act && (lane == LANE_W'(g));
      end
   endgenerate

   assign rx_word = rx_data[int'(lane)*DATA_W +: DATA_W];
   assign xfer    = (|(tx_valid & tx_ready)) || (|(rx_ready & rx_valid));
endmodule

// File: rtl/mbf_seq.sv
module mbf_seq
   import mbf_pkg::*;
#(
   parameter int IDX_W = 3,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_op,
   input  logic             req_no_resp,
   input  logic             xfer,
   input  logic             oversize,
   input  logic [CNT_W-1:0] eff_len,
   output logic             tx_act,
   output logic             rx_act,
   output logic [IDX_W-1:0] idx,
   output logic             wr_en,
   output logic             zero_hdr,
   output logic             busy,
   output logic             done,
   output logic             err
);
   mbf_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] total_q;
   logic             call_q, nr_q, done_q, err_q;
   logic             hdr_phase, last;

   assign hdr_phase = (idx_q == '0);
   assign last      = hdr_phase ? (eff_len == CNT_W'(1))
                                : (CNT_W'(idx_q) + CNT_W'(1) >= total_q);

   assign tx_act   = (state_q == ST_SEND) && !(hdr_phase && oversize);
   assign rx_act   = (state_q == ST_RECV);
   assign wr_en    = rx_act && xfer;
   assign zero_hdr = wr_en && hdr_phase && oversize;
   assign idx      = idx_q;
   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign err      = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         total_q <= '0;
         call_q  <= 1'b0;
         nr_q    <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               idx_q <= '0;
               if (req_valid) begin
                  call_q  <= req_op[1];
                  nr_q    <= req_no_resp;
                  state_q <= (req_op == OP_RECV) ? ST_RECV : ST_SEND;
               end
            end
            ST_SEND: begin
               if (hdr_phase && oversize) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  err_q   <= 1'b1;
               end else if (xfer) begin
                  if (hdr_phase) total_q <= eff_len;
                  if (last) begin
                     idx_q <= '0;
                     if (call_q && !nr_q) begin
                        state_q <= ST_RECV;
                     end else begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            ST_RECV: begin
               if (xfer) begin
                  if (hdr_phase && oversize) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     err_q   <= 1'b1;
                  end else begin
                     if (hdr_phase) total_q <= eff_len;
                     if (last) begin
                        idx_q   <= '0;
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        idx_q <= idx_q + IDX_W'(1);
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R8: completion pulse lasts one cycle
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8: busy only ends together with done
   a_r8_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   // R8: an idle request is taken on the next edge
   a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> busy);
   // R4 / R5: error is only reported on completion
   a_r4_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);
endmodule

// File: rtl/mbox_msg_framer.sv
module mbox_msg_framer #(
   parameter int DATA_W    = 32,
   parameter int NUM_REGS  = 4,
   parameter int MAX_WORDS = 8,
   parameter int LEN_LSB   = 8,
   parameter int LEN_W     = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 req_valid,
   input  logic [1:0]                           req_op,
   input  logic                                 req_no_resp,
   output logic                                 busy,
   output logic                                 done,
   output logic                                 err,
   output logic [$clog2(MAX_WORDS)-1:0]         buf_addr,
   input  logic [DATA_W-1:0]                    buf_rd_data,
   output logic                                 buf_wr_en,
   output logic [DATA_W-1:0]                    buf_wr_data,
   output logic [NUM_REGS-1:0]                  tx_valid,
   output logic [DATA_W-1:0]                    tx_data,
   input  logic [NUM_REGS-1:0]                  tx_ready,
   input  logic [NUM_REGS-1:0]                  rx_valid,
   input  logic [NUM_REGS*DATA_W-1:0]           rx_data,
   output logic [NUM_REGS-1:0]                  rx_ready
);
   localparam int IDX_W = $clog2(MAX_WORDS);
   localparam int CNT_W = $clog2(MAX_WORDS + 1);

   generate
      if (LEN_LSB + LEN_W > DATA_W) begin : g_bad_field
         $error("length field does not fit in a word");
      end
      if (MAX_WORDS < 2) begin : g_bad_max
         $error("MAX_WORDS must be at least 2");
      end
      if (MAX_WORDS >= (1 << LEN_W)) begin : g_bad_len_w
         $error("length field too narrow for MAX_WORDS");
      end
      if (NUM_REGS < 1) begin : g_bad_regs
         $error("NUM_REGS must be at least 1");
      end
   endgenerate

   logic             tx_act, rx_act, xfer, len_over, wr_en, zero_hdr;
   logic [IDX_W-1:0] idx;
   logic [CNT_W-1:0] eff_len;
   logic [DATA_W-1:0] rx_word;
   logic [LEN_W-1:0]  len_field;

   assign len_field = rx_act ? rx_word[LEN_LSB +: LEN_W]
                             : buf_rd_data[LEN_LSB +: LEN_W];

   mbf_len_check #(.LEN_W(LEN_W), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) u_len (
      .len_field (len_field),
      .oversize  (len_over),
      .eff_len   (eff_len)
   );

   mbf_lane_sel #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_lane (
      .tx_act   (tx_act),
      .rx_act   (rx_act),
      .idx      (idx),
      .tx_ready (tx_ready),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .tx_valid (tx_valid),
      .rx_ready (rx_ready),
      .rx_word  (rx_word),
      .xfer     (xfer)
   );

   mbf_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_op      (req_op),
      .req_no_resp (req_no_resp),
      .xfer        (xfer),
      .oversize    (len_over),
      .eff_len     (eff_len),
      .tx_act      (tx_act),
      .rx_act      (rx_act),
      .idx         (idx),
      .wr_en       (wr_en),
      .zero_hdr    (zero_hdr),
      .busy        (busy),
      .done        (done),
      .err         (err)
   );

   assign buf_addr    = idx;
   assign tx_data     = buf_rd_data;
   assign buf_wr_en   = wr_en;
   assign buf_wr_data = zero_hdr ? '0 : rx_word;

   // R1: header always on register 0
   a_r1_hdr_reg0: assert property (@(posedge clk) disable iff (!rst_n)
      (((|tx_valid) || (|rx_ready)) && buf_addr == '0) |-> (tx_valid[0] || rx_ready[0]));
   // R2: one lane at a time, chosen by index
   a_r2_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_valid) && $onehot0(rx_ready) && !((|tx_valid) && (|rx_ready)));
   a_r2_lane_index: assert property (@(posedge clk) disable iff (!rst_n)
      (|tx_valid) |-> tx_valid[int'(buf_addr) % NUM_REGS]);
   // R3: pending requests hold until their flag arrives
   a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((|tx_valid) && !(|(tx_valid & tx_ready))) |=> (tx_valid == $past(tx_valid)));
   a_r3_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((|rx_ready) && !(|(rx_ready & rx_valid))) |=> (rx_ready == $past(rx_ready)));
   a_r3_wr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en |-> (|(rx_valid & rx_ready)));
   // R4: no word leaves on an oversized header
   a_r4_no_tx_oversize: assert property (@(posedge clk) disable iff (!rst_n)
      ((|tx_valid) && buf_addr == '0) |-> !len_over);
   // R5: oversized received header is stored as zero
   a_r5_zero_hdr: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_wr_en && buf_addr == '0 && len_over) |-> (buf_wr_data == '0));
endmodule

// File: tb/mbox_msg_framer_test.sv
module mbox_msg_framer_test;
   localparam int DW = 32;
   localparam int NR = 4;
   localparam int MW = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n, req_valid, req_no_resp;
   logic [1:0]    req_op;
   logic          busy, done, err, buf_wr_en;
   logic [IW-1:0] buf_addr;
   logic [DW-1:0] buf_rd_data, buf_wr_data, tx_data;
   logic [NR-1:0] tx_valid, tx_ready, rx_valid, rx_ready;
   logic [NR*DW-1:0] rx_data;

   mbox_msg_framer uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_no_resp(req_no_resp), .busy(busy), .done(done), .err(err),
      .buf_addr(buf_addr), .buf_rd_data(buf_rd_data), .buf_wr_en(buf_wr_en),
      .buf_wr_data(buf_wr_data), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_ready(rx_ready)
   );

   logic [DW-1:0] mem [0:MW-1];
   logic [DW-1:0] mem_next [0:MW-1];
   logic [DW-1:0] rx_q [0:15];
   logic [DW-1:0] tx_word [0:15];
   int            tx_lane [0:15];
   int            rx_n = 0, rx_pos = 0, tx_cnt = 0, hold_err = 0;
   logic          ld_all = 1'b0, stall_mode = 1'b0, gate = 1'b1;
   logic [15:0]   lfsr = 16'hACE1;
   logic          prev_pend = 1'b0;
   logic [NR-1:0] prev_v = '0;
   int            checks = 0, errors = 0;

   assign buf_rd_data = mem[buf_addr];
   assign tx_ready    = (stall_mode && !gate) ? '0 : '1;

   always_comb begin
      rx_valid = '0;
      rx_data  = '0;
      if (rx_pos < rx_n && (!stall_mode || gate)) rx_valid[rx_pos % NR] = 1'b1;
      for (int l = 0; l < NR; l++)
         rx_data[l*DW +: DW] = (rx_pos < 16) ? rx_q[rx_pos] : '0;
   end

   always @(posedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gate <= lfsr[0] | lfsr[5];
      if (ld_all) begin
         for (int k = 0; k < MW; k++) mem[k] <= mem_next[k];
         tx_cnt   <= 0;
         rx_pos   <= 0;
         hold_err <= 0;
      end else begin
         if (buf_wr_en) mem[buf_addr] <= buf_wr_data;
         if (|(tx_valid & tx_ready)) begin
            for (int l = 0; l < NR; l++)
               if (tx_valid[l]) tx_lane[tx_cnt % 16] <= l;
            tx_word[tx_cnt % 16] <= tx_data;
            tx_cnt <= tx_cnt + 1;
         end
         if (|(rx_valid & rx_ready)) rx_pos <= rx_pos + 1;
         if ((prev_pend && tx_valid != prev_v) ||
             (buf_wr_en && !(|(rx_valid & rx_ready))))
            hold_err <= hold_err + 1;
      end
      prev_pend <= (|tx_valid) && !(|(tx_valid & tx_ready));
      prev_v    <= tx_valid;
   end

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] hdr(int len, int sid);
      return {8'hC0, 8'(sid), 8'(len), 8'h5A};
   endfunction

   task automatic load();
      @(negedge clk); ld_all = 1'b1;
      @(negedge clk); ld_all = 1'b0;
   endtask

   // Issue a request, poke an ignored request while busy, wait for done.
   task automatic run(logic [1:0] op, logic nr, output logic got_err);
      bit seen = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_no_resp = nr;
      @(negedge clk);
      chk("R8 busy after accept", 32'(busy), 1);
      req_op = 2'b01;
      for (int i = 0; i < 400; i++) begin
         if (i == 1) req_valid = 1'b0;
         if (done) begin seen = 1; break; end
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk("R8 done seen", 32'(seen), 1);
      got_err = err;
      @(negedge clk);
      chk("R8 done one cycle", 32'(done), 0);
      chk("R8 idle after done", 32'(busy), 0);
      repeat (3) @(negedge clk);
      chk("R8 request while busy ignored", 32'(busy), 0);
   endtask

   task automatic send_case(int len, int sid);
      logic e;
      int n = (len < 2) ? 1 : len;
      for (int k = 0; k < MW; k++) mem_next[k] = 32'h1000_0000 + sid * 256 + k;
      mem_next[0] = hdr(len, sid);
      rx_n = 0;
      load();
      run(2'b00, 1'b0, e);
      if (len > MW) begin
         chk("R4 oversized send sends nothing", tx_cnt, 0);
         chk("R4 oversized send err", 32'(e), 1);
      end else begin
         chk(len < 2 ? "R6 header-only count" : "R1 send word count", tx_cnt, n);
         chk("R4 no err on legal length", 32'(e), 0);
         chk("R1 header on register 0", tx_lane[0], 0);
         chk("R1 header word", tx_word[0], mem_next[0]);
         for (int k = 1; k < n; k++) begin
            chk("R2 send lane k mod 4", tx_lane[k], k % NR);
            chk("R2 send word from address k", tx_word[k], mem_next[k]);
         end
      end
      chk("R3 send held until empty flag", hold_err, 0);
   endtask

   task automatic recv_case(int len, int sid);
      logic e;
      int n = (len < 2) ? 1 : len;
      for (int k = 0; k < MW; k++) mem_next[k] = 32'hDEAD_0000 + k;
      for (int k = 0; k < 16; k++) rx_q[k] = 32'h2000_0000 + sid * 256 + k;
      rx_q[0] = hdr(len, sid);
      rx_n = (len > MW) ? 4 : n + 3;
      load();
      run(2'b01, 1'b0, e);
      if (len > MW) begin
         chk("R5 oversized header stored as zero", mem[0], 0);
         chk("R5 only header taken", rx_pos, 1);
         chk("R5 later words untouched", mem[1], 32'hDEAD_0001);
         chk("R5 err", 32'(e), 1);
      end else begin
         chk(len < 2 ? "R6 header-only receive count" : "R1 receive word count", rx_pos, n);
         chk("R5 no err on legal length", 32'(e), 0);
         for (int k = 0; k < n; k++)
            chk("R2 received word at address k", mem[k], rx_q[k]);
         if (n < MW) chk("R2 address past length untouched", mem[n], 32'hDEAD_0000 + n);
      end
      chk("R3 receive writes only on full flag", hold_err, 0);
   endtask

   task automatic call_case(int tlen, int rlen, logic nr, logic [1:0] op, int sid);
      logic e;
      int tn = (tlen < 2) ? 1 : tlen;
      int rn = (rlen < 2) ? 1 : rlen;
      for (int k = 0; k < MW; k++) mem_next[k] = 32'h3000_0000 + sid * 256 + k;
      mem_next[0] = hdr(tlen, sid);
      for (int k = 0; k < 16; k++) rx_q[k] = 32'h4000_0000 + sid * 256 + k;
      rx_q[0] = hdr(rlen, sid + 1);
      rx_n = 12;
      load();
      run(op, nr, e);
      if (tlen > MW) begin
         chk("R7 failed call sends nothing", tx_cnt, 0);
         chk("R7 failed call receives nothing", rx_pos, 0);
         chk("R4 failed call err", 32'(e), 1);
      end else begin
         chk("R7 call sends full request", tx_cnt, tn);
         if (nr) begin
            chk("R7 no-response call receives nothing", rx_pos, 0);
            chk("R7 buffer keeps request", mem[0], mem_next[0]);
            chk("R7 no-response err", 32'(e), 0);
         end else if (rlen > MW) begin
            chk("R5 oversized reply header zeroed", mem[0], 0);
            chk("R5 reply stops after header", rx_pos, 1);
            chk("R5 reply err", 32'(e), 1);
         end else begin
            chk("R7 reply length", rx_pos, rn);
            for (int k = 0; k < rn; k++)
               chk("R7 reply into same buffer", mem[k], rx_q[k]);
            chk("R7 reply err", 32'(e), 0);
         end
      end
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_no_resp = 1'b0;
      for (int k = 0; k < MW; k++) mem_next[k] = '0;
      for (int k = 0; k < 16; k++) rx_q[k] = '0;
      load();
      repeat (2) @(negedge clk);
      chk("R9 busy low in reset", 32'(busy), 0);
      chk("R9 done low in reset", 32'(done), 0);
      chk("R9 err low in reset", 32'(err), 0);
      chk("R9 no tx valid in reset", 32'(tx_valid), 0);
      chk("R9 no rx ready in reset", 32'(rx_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 idle after reset", 32'(busy), 0);

      for (int s = 0; s < 2; s++) begin
         stall_mode = s[0];
         for (int len = 0; len <= MW + 2; len++) send_case(len, s * 32 + len);
         for (int len = 0; len <= MW + 2; len++) recv_case(len, s * 32 + len + 16);
         call_case(3, 5, 1'b0, 2'b10, 100 + s);
         call_case(5, 2, 1'b0, 2'b11, 110 + s);
         call_case(3, 5, 1'b1, 2'b10, 120 + s);
         call_case(9, 4, 1'b0, 2'b10, 130 + s);
         call_case(2, 12, 1'b0, 2'b10, 140 + s);
         call_case(8, 8, 1'b0, 2'b10, 150 + s);
      end

      summary();
      $finish;
   end
endmodule